// File: doc/BRIEF.md
# Stereo Auto-Mute Detector

This block sits in the digital datapath of a stereo DAC and decides when each output channel is muted. It watches the left and right sample streams. Each stream has a per-channel valid strobe and a sample word. When both channels have carried a long unbroken run of static samples, it raises a shared automatic mute. A sample is static when it is all zeros or all ones. The mute falls as soon as either channel delivers a sample that is not static.

An active-low enable gates the automatic mute. Two manual mute requests, one per channel, silence their own channel at the next clock edge. The manual requests play no part in the automatic decision. Each final mute output is the OR of that channel's manual request and the shared automatic mute. Both outputs are registered.

Top module: `stereo_automute`

## Requirements
- R1: A sample word of DATA_W bits counts as static when every bit is 0 or every bit is 1. Any other word is non-static.
- R2: With auto_en_n low, both mute outputs go high at the clock edge that registers the RUN_LEN-th consecutive valid static sample on each channel (default RUN_LEN = 8192). They stay low after RUN_LEN-1 such samples.
- R3: Each channel's run count saturates at RUN_LEN, so the automatic mute holds through static runs of any length.
- R4: A cycle with a channel's valid low is not counted on that channel and does not break its run, whatever its data.
- R5: A valid non-static sample on either channel drops the automatic mute at the edge that registers it. That channel's run restarts from zero, and the other channel keeps its count.
- R6: A static run on only one channel never raises the automatic mute.
- R7: While auto_en_n is high, the automatic mute is off from the next edge and both run counts are cleared.
- R8: A high manual request on one channel sets that channel's mute output at the next edge and leaves the other channel's output unchanged.
- R9: Counting and release of the automatic mute do not depend on the manual requests. Each output is the OR of its manual request and the automatic mute.
- R10: After reset both mute outputs are low and both run counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en_n | input | 1 | Active-low enable of the automatic mute |
| l_valid | input | 1 | Left sample strobe |
| l_data | input | DATA_W | Left sample word |
| r_valid | input | 1 | Right sample strobe |
| r_data | input | DATA_W | Right sample word |
| l_mute_req | input | 1 | Manual mute request, left |
| r_mute_req | input | 1 | Manual mute request, right |
| l_mute | output | 1 | Registered left mute |
| r_mute | output | 1 | Registered right mute |

## Verification
The hardest state to reach from the ports is one where the two run counts differ by thousands. For example, one channel sits saturated while the other has just restarted, and the mute must wait exactly RUN_LEN fresh samples on the restarted side. The bench builds this case with a full static run, then one non-static sample on the left only, then RUN_LEN-1 and one more static samples. It checks that the mute returns on the last sample and not before. It also splits a run with invalid non-static cycles and with an enable pulse, so that every count boundary lands on a known edge.

// File: rtl/am_pkg.sv
package am_pkg;
  localparam int NUM_CH = 2;
  typedef enum logic {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/am_static_det.sv
module am_static_det #(
  parameter int DATA_W = 20
) (
  input  logic [DATA_W-1:0] word,
  output logic              is_static
);
  always_comb begin
    is_static = (word == '0) || (&word);
  end
endmodule

// File: rtl/am_run_ctr.sv
module am_run_ctr #(
  parameter int DATA_W  = 20,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              valid,
  input  logic [DATA_W-1:0] data,
  output logic              full_next
);
  localparam int CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(RUN_LEN);

  logic             stat;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  am_static_det #(.DATA_W(DATA_W)) u_det (.word(data), .is_static(stat));

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (valid) begin
      if (!stat)                cnt_d = '0;
      else if (cnt_q != RUN_MAX) cnt_d = cnt_q + CNT_W'(1);
    end
    full_next = (cnt_d == RUN_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= RUN_MAX);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!valid && !clr) |=> $stable(cnt_q));

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/stereo_automute.sv
module stereo_automute #(
  parameter int DATA_W  = 20,
  parameter int RUN_LEN = 8192
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_en_n,
  input  logic              l_valid,
  input  logic [DATA_W-1:0] l_data,
  input  logic              r_valid,
  input  logic [DATA_W-1:0] r_data,
  input  logic              l_mute_req,
  input  logic              r_mute_req,
  output logic              l_mute,
  output logic              r_mute
);
  import am_pkg::*;

  logic [NUM_CH-1:0] vld, req, full_nx, mute_q;
  logic [DATA_W-1:0] smp [NUM_CH];
  logic              auto_now, auto_q;

  always_comb begin
    vld[CH_LEFT]  = l_valid;
    vld[CH_RIGHT] = r_valid;
    req[CH_LEFT]  = l_mute_req;
    req[CH_RIGHT] = r_mute_req;
    smp[CH_LEFT]  = l_data;
    smp[CH_RIGHT] = r_data;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    am_run_ctr #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_ctr (
      .clk(clk), .rst(rst), .clr(auto_en_n),
      .valid(vld[ch]), .data(smp[ch]), .full_next(full_nx[ch])
    );
  end

  assign auto_now = (&full_nx) & ~auto_en_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_q <= '0;
      auto_q <= 1'b0;
    end else begin
      mute_q <= req | {NUM_CH{auto_now}};
      auto_q <= auto_now;
    end
  end

  assign l_mute = mute_q[CH_LEFT];
  assign r_mute = mute_q[CH_RIGHT];

  // R8
  man_left_chk: assert property (@(posedge clk) disable iff (rst)
    l_mute_req |=> l_mute);

  // R8
  man_right_chk: assert property (@(posedge clk) disable iff (rst)
    r_mute_req |=> r_mute);

  // R5
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (l_valid && !((l_data == '0) || (&l_data)) && !r_mute_req) |=> !r_mute);

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    auto_en_n |=> !auto_q);

  // R9
  shared_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_mute_req && !r_mute_req) |=> (l_mute == r_mute));
endmodule

// File: tb/sim_stereo_automute.sv
module sim_stereo_automute;
  localparam int DW = 20;
  localparam int RL = 8192;

  logic clk = 1'b0;
  logic rst, en_n, lv, rv, lreq, rreq, lm, rm;
  logic [DW-1:0] ld, rd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stereo_automute #(.DATA_W(DW), .RUN_LEN(RL)) u0 (
    .clk(clk), .rst(rst), .auto_en_n(en_n),
    .l_valid(lv), .l_data(ld), .r_valid(rv), .r_data(rd),
    .l_mute_req(lreq), .r_mute_req(rreq), .l_mute(lm), .r_mute(rm)
  );

  task automatic check(string rq, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  // Feed n samples on both channels; the following negedge idles and leaves outputs ready.
  task automatic feed(int n, logic [DW-1:0] a, logic [DW-1:0] b,
                      logic va = 1'b1, logic vb = 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lv = va; rv = vb; ld = a; rd = b;
    end
    @(negedge clk); lv = 1'b0; rv = 1'b0;
  endtask

  task automatic t_reset;
    check("R10", "l_mute after reset", lm, 1'b0);
    check("R10", "r_mute after reset", rm, 1'b0);
  endtask

  task automatic t_manual;
    @(negedge clk); lreq = 1'b1;
    @(negedge clk);
    check("R8", "left manual", lm, 1'b1);
    check("R8", "right untouched", rm, 1'b0);
    lreq = 1'b0; rreq = 1'b1;
    @(negedge clk);
    check("R8", "right manual", rm, 1'b1);
    check("R8", "left released", lm, 1'b0);
    rreq = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_zero_run;
    feed(RL - 1, '0, '0);
    check("R2", "no mute at RUN_LEN-1", lm, 1'b0);
    feed(1, '0, '0);
    check("R2", "left mute at RUN_LEN", lm, 1'b1);
    check("R2", "right mute at RUN_LEN", rm, 1'b1);
    feed(1000, '0, '0);
    check("R3", "mute held past RUN_LEN", rm, 1'b1);
  endtask

  task automatic t_release;
    feed(1, 20'h00005, '0);
    check("R5", "left released by non-static", lm, 1'b0);
    check("R5", "right released too", rm, 1'b0);
    feed(RL - 1, '0, '0);
    check("R5", "left run restarted", lm, 1'b0);
    feed(1, '0, '0);
    check("R5", "mute after fresh left run", rm, 1'b1);
  endtask

  task automatic t_ones_mixed;
    feed(1, 20'h12345, 20'h00F00);
    check("R1", "cleared before ones run", lm, 1'b0);
    feed(RL, '1, '0);
    check("R1", "all-ones counts as static", lm, 1'b1);
    feed(1, 20'hFFFFE, '0);
    check("R1", "near-ones word is non-static", rm, 1'b0);
  endtask

  task automatic t_one_side;
    feed(RL + 500, '0, 20'h00003);
    check("R6", "left-only static never mutes", lm, 1'b0);
    check("R6", "right stays open", rm, 1'b0);
  endtask

  task automatic t_gaps;
    feed(1, 20'h00001, 20'h00001);
    feed(4000, '0, '1);
    feed(50, 20'h0F0F0, 20'h0F0F0, 1'b0, 1'b0);
    check("R4", "no mute mid-gap", lm, 1'b0);
    feed(RL - 4001, '0, '1);
    check("R4", "gap not counted", lm, 1'b0);
    feed(1, '0, '1);
    check("R4", "gap did not break run", lm, 1'b1);
  endtask

  task automatic t_enable;
    feed(1, 20'h00001, 20'h00001);
    feed(5000, '0, '0);
    @(negedge clk); en_n = 1'b1;
    @(negedge clk); en_n = 1'b0;
    feed(5000, '0, '0);
    check("R7", "enable pulse cleared counts", lm, 1'b0);
    feed(RL - 5000, '0, '0);
    check("R7", "mute after full run post-pulse", lm, 1'b1);
    @(negedge clk); en_n = 1'b1;
    @(negedge clk);
    check("R7", "mute drops while disabled", rm, 1'b0);
    feed(RL + 10, '0, '0);
    check("R7", "no mute while disabled", lm, 1'b0);
    en_n = 1'b0;
  endtask

  task automatic t_indep;
    @(negedge clk); lreq = 1'b1;
    feed(RL - 1, '0, '0);
    check("R9", "right waits despite left manual", rm, 1'b0);
    check("R9", "left held by manual", lm, 1'b1);
    feed(1, '0, '0);
    check("R9", "right mutes on schedule", rm, 1'b1);
    feed(1, '0, 20'h00100);
    check("R9", "right released", rm, 1'b0);
    check("R9", "left kept by manual", lm, 1'b1);
    lreq = 1'b0;
    @(negedge clk);
    check("R9", "left drops with manual", lm, 1'b0);
  endtask

  initial begin
    rst = 1'b1; en_n = 1'b0; lv = 1'b0; rv = 1'b0;
    ld = '0; rd = '0; lreq = 1'b0; rreq = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_manual();
    t_zero_run();
    t_release();
    t_ones_mixed();
    t_one_side();
    t_gaps();
    t_enable();
    t_indep();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule